// File: doc/BRIEF.md
# Byte-Length SPI Shift Engine

This block is an SPI master that serialises a whole number of bytes from a 56-bit holding register and collects what the peripheral returns. Loading the holding register and starting a transfer are two separate strobes. Software-side logic first pulses `load_i` to capture `tx_data_i`. It then pulses `go_i` with a byte count on `nbytes_i` and a half-period length on `div_i`. `ready_o` drops for the whole transfer and rises again once the chip select has been released.

The serial side runs in mode 0. `sclk_o` idles low. `mosi_o` changes only when `sclk_o` falls, and `miso_i` is sampled when `sclk_o` rises. Bits leave most significant first, starting at bit 55. Incoming bits enter at the least significant end of a 32-bit register, so `rx_data_o` always shows the last 32 bits received.

The control is a five-state machine:
- `ST_IDLE` goes to `ST_LEAD` when a start is taken with a non-zero count.
- `ST_LEAD` goes to `ST_HIGH` after one half-period.
- `ST_HIGH` goes to `ST_LOW` after one half-period, or to `ST_TRAIL` if it was the final bit.
- `ST_LOW` goes back to `ST_HIGH` after one half-period.
- `ST_TRAIL` returns to `ST_IDLE` after one half-period.

Top module: `spi_byte_shifter`

## Requirements
- R1: After reset, `ready_o`=1, `csn_o`=1, `sclk_o`=0 and `rx_data_o`=0.
- R2: A `load_i` pulse while idle copies `tx_data_i` into the holding register and starts nothing: `ready_o` and `csn_o` stay 1 and `sclk_o` stays 0.
- R3: A `go_i` pulse while idle with `nbytes_i`=N, where N is 1 to 7, produces exactly 8N rising edges of `sclk_o`. The bit on `mosi_o` at rising edge k (k from 0) is holding-register bit 55-k.
- R4: Each `sclk_o` half-period lasts D system clocks, where D is `div_i` latched at start and a value of 0 is treated as 1. `ready_o` is low for exactly D*(16N+1) cycles.
- R5: Mode 0. `sclk_o` is low whenever `csn_o` is high, `mosi_o` is stable while `sclk_o` is high, and `miso_i` is captured at each rising edge.
- R6: `csn_o` falls D cycles before the first rising edge of `sclk_o`, and it rises D cycles after the last falling edge.
- R7: A start with `nbytes_i`=0 produces no bus activity. `ready_o` stays 1 and `rx_data_o` is unchanged.
- R8: `rx_data_o` is cleared when a transfer starts. Each captured bit then enters at bit 0, so the output ends holding the last min(8N,32) received bits, right-aligned. Once idle it stays stable until the next start.
- R9: While a transfer runs, `load_i`, `go_i` and changes on `div_i` and `nbytes_i` have no effect on the transmitted bits or the timing.
- R10: `ready_o` is high exactly while the engine is idle, and it equals `csn_o` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture `tx_data_i` into the holding register (idle only) |
| go_i | input | 1 | Start a transfer (idle only) |
| nbytes_i | input | 3 | Number of bytes to transfer |
| div_i | input | 16 | Half-period length in system clocks |
| tx_data_i | input | 56 | Data to transmit |
| ready_o | output | 1 | High while idle |
| rx_data_o | output | 32 | Last 32 received bits |
| sclk_o | output | 1 | Serial clock |
| csn_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench loops `mosi_o` back inverted into `miso_i`. A wrong sampling edge or a wrong shift direction therefore shows up as a wrong `rx_data_o` and wrong captured bits. It measures the busy time, the lead time and the trail time in cycles, for several divisors including 0. An off-by-one half-period counter would change each of these counts.

Other corner cases are driven directly:
- A zero-byte start. A design that started anyway would drop `ready_o`.
- A full seven-byte frame. A design whose byte count truncated would send too few edges.
- A reload, a restart and new divisor and length values in the middle of a transfer. A design that failed to latch or gate these would corrupt the bit stream or its length.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL
    } eng_state_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: the half-period counter never passes the latched length
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < half_len));

endmodule

// File: rtl/spi_bit_tracker.sv
module spi_bit_tracker #(
    parameter int BIT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [BIT_W-1:0] total,
    output logic             last
);

    logic [BIT_W-1:0] done_q;

    assign last = (done_q == total - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
        end else if (clear) begin
            done_q <= '0;
        end else if (step) begin
            done_q <= done_q + 1'b1;
        end
    end

    // R3: a bit is never advanced past the requested frame length
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (done_q < total));

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter int TX_W = 56,
    parameter int RX_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_data,
    input  logic            shift_out,
    input  logic            clear_rx,
    input  logic            capture,
    input  logic            serial_in,
    output logic            serial_out,
    output logic [RX_W-1:0] rx_word
);

    logic [TX_W-1:0] tx_q;
    logic [RX_W-1:0] rx_q;

    assign serial_out = tx_q[TX_W-1];
    assign rx_word    = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (shift_out) begin
            tx_q <= {tx_q[TX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (clear_rx) begin
            rx_q <= '0;
        end else if (capture) begin
            rx_q <= {rx_q[RX_W-2:0], serial_in};
        end
    end

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_eng_pkg::*;
#(
    parameter int TX_W  = 56,
    parameter int RX_W  = 32,
    parameter int LEN_W = 3,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             go_i,
    input  logic [LEN_W-1:0] nbytes_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [TX_W-1:0]  tx_data_i,
    output logic             ready_o,
    output logic [RX_W-1:0]  rx_data_o,
    output logic             sclk_o,
    output logic             csn_o,
    output logic             mosi_o,
    input  logic             miso_i
);

    localparam int BIT_W = LEN_W + 3;

    eng_state_t       state_q, state_nx;
    logic [DIV_W-1:0] half_q;
    logic [BIT_W-1:0] total_q;
    logic             tick, last_bit;
    logic             start_take, do_capture, do_shift;
    logic             sclk_q, csn_q;

    assign start_take = (state_q == ST_IDLE) && go_i && (nbytes_i != '0);
    assign do_capture = tick && ((state_q == ST_LEAD) || (state_q == ST_LOW));
    assign do_shift   = tick && (state_q == ST_HIGH) && !last_bit;

    // settings are captured only when a start is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= DIV_W'(1);
            total_q <= BIT_W'(8);
        end else if (start_take) begin
            half_q  <= (div_i == '0) ? DIV_W'(1) : div_i;
            total_q <= {nbytes_i, 3'b000};
        end
    end

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .half_len (half_q),
        .tick     (tick)
    );

    spi_bit_tracker #(.BIT_W(BIT_W)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_take),
        .step  (do_shift),
        .total (total_q),
        .last  (last_bit)
    );

    spi_shift_path #(.TX_W(TX_W), .RX_W(RX_W)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_i && (state_q == ST_IDLE)),
        .load_data  (tx_data_i),
        .shift_out  (do_shift),
        .clear_rx   (start_take),
        .capture    (do_capture),
        .serial_in  (miso_i),
        .serial_out (mosi_o),
        .rx_word    (rx_data_o)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_take) state_nx = ST_LEAD;
            ST_LEAD:  if (tick)       state_nx = ST_HIGH;
            ST_HIGH:  if (tick)       state_nx = last_bit ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick)       state_nx = ST_HIGH;
            ST_TRAIL: if (tick)       state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= (state_nx == ST_HIGH);
            csn_q  <= (state_nx == ST_IDLE);
        end
    end

    assign sclk_o  = sclk_q;
    assign csn_o   = csn_q;
    assign ready_o = (state_q == ST_IDLE);

    a_r10_ready_is_csn: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o == csn_o);
    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        csn_o |-> !sclk_o);
    a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(mosi_o));
    a_r7_zero_len_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && go_i && nbytes_i == '0) |=> ready_o);
    a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(ready_o)) |-> $stable(rx_data_o));

endmodule

// File: tb/test_spi_byte_shifter.sv
module test_spi_byte_shifter;

    typedef struct packed {
        logic [55:0] d;
        logic [2:0]  n;
        logic [15:0] dv;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{56'hDEADBEEFF18244, 3'd4, 16'd3},
        '{56'hA50F3C9671E25B, 3'd1, 16'd1},
        '{56'h0123456789ABCD, 3'd7, 16'd2},
        '{56'hFF00FF00FF00FF, 3'd5, 16'd1},
        '{56'h80000000000001, 3'd2, 16'd4},
        '{56'h5A5A5A5A5A5A5A, 3'd3, 16'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0, go_i = 1'b0;
    logic [2:0]  nbytes_i = '0;
    logic [15:0] div_i = 16'd1;
    logic [55:0] tx_data_i = '0;
    logic        ready_o, sclk_o, csn_o, mosi_o, miso_i;
    logic [31:0] rx_data_o;

    int checks = 0, fails = 0;
    int busy_n, rises, lead_n, trail_n, csn_low_n;
    logic [63:0] sent;
    logic        prev_sclk;

    always #10 clk = ~clk;

    assign miso_i = ~mosi_o;

    spi_byte_shifter i_spi_byte_shifter (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .go_i(go_i),
        .nbytes_i(nbytes_i), .div_i(div_i), .tx_data_i(tx_data_i),
        .ready_o(ready_o), .rx_data_o(rx_data_o), .sclk_o(sclk_o),
        .csn_o(csn_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    task automatic clear_mon();
        busy_n = 0; rises = 0; lead_n = 0; trail_n = 0; csn_low_n = 0;
        sent = '0;
    endtask

    always @(negedge clk) begin
        if (!ready_o) busy_n++;
        if (!csn_o) csn_low_n++;
        if (!csn_o && !sclk_o && rises == 0) lead_n++;
        if (sclk_o && !prev_sclk) begin
            rises++;
            sent = {sent[62:0], mosi_o};
        end
        if (!sclk_o && prev_sclk) trail_n = 1;
        else if (!csn_o && !sclk_o && rises != 0) trail_n++;
        prev_sclk = sclk_o;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic strobe_load(input logic [55:0] d);
        @(posedge clk); #1 tx_data_i = d; load_i = 1'b1;
        @(posedge clk); #1 load_i = 1'b0;
    endtask

    task automatic strobe_go(input logic [2:0] n, input logic [15:0] dv);
        @(posedge clk); #1 nbytes_i = n; div_i = dv; go_i = 1'b1;
        @(posedge clk); #1 go_i = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        @(negedge clk); #1;
    endtask

    function automatic logic [63:0] top_bits(input logic [55:0] d, input int n);
        logic [63:0] t;
        t = {8'h00, d} >> (56 - 8 * n);
        return t & ((64'd1 << (8 * n)) - 64'd1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] exp_sent, exp_rx;
        int          eff;
        prev_sclk = 1'b0;
        clear_mon();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk(ready_o == 1'b1, "R1", "ready", 64'(ready_o), 1);
        chk(csn_o == 1'b1, "R1", "csn", 64'(csn_o), 1);
        chk(sclk_o == 1'b0, "R1", "sclk", 64'(sclk_o), 0);
        chk(rx_data_o == 32'd0, "R1", "rx", 64'(rx_data_o), 0);

        // R2: load alone starts nothing
        clear_mon();
        strobe_load(56'hC3C3C3C3C3C3C3);
        repeat (6) @(negedge clk);
        chk(busy_n == 0, "R2", "busy cycles after load", 64'(busy_n), 0);
        chk(csn_low_n == 0 && rises == 0, "R2", "bus activity", 64'(rises), 0);

        // table of vectors: R3 R4 R5 R6 R8 R10
        foreach (VECS[i]) begin
            clear_mon();
            strobe_load(VECS[i].d);
            strobe_go(VECS[i].n, VECS[i].dv);
            wait_done();
            eff = int'(VECS[i].dv);
            exp_sent = top_bits(VECS[i].d, int'(VECS[i].n));
            exp_rx   = 64'((~exp_sent & ((64'd1 << (8 * VECS[i].n)) - 64'd1)) & 64'hFFFF_FFFF);
            chk(rises == 8 * VECS[i].n, "R3", "rising edges", 64'(rises), 64'(8 * VECS[i].n));
            chk(sent == exp_sent, "R3", "bits sent", sent, exp_sent);
            chk(busy_n == eff * (16 * VECS[i].n + 1), "R4", "busy cycles",
                64'(busy_n), 64'(eff * (16 * VECS[i].n + 1)));
            chk(lead_n == eff, "R6", "lead cycles", 64'(lead_n), 64'(eff));
            chk(trail_n == eff, "R6", "trail cycles", 64'(trail_n), 64'(eff));
            chk(64'(rx_data_o) == exp_rx, "R5", "captured rx", 64'(rx_data_o), exp_rx);
            chk(csn_low_n == busy_n, "R10", "csn low vs busy", 64'(csn_low_n), 64'(busy_n));
        end

        // R8: rx held while idle
        exp_rx = 64'(rx_data_o);
        repeat (10) @(negedge clk);
        chk(64'(rx_data_o) == exp_rx, "R8", "rx hold idle", 64'(rx_data_o), exp_rx);

        // R7: zero-length start
        clear_mon();
        strobe_go(3'd0, 16'd2);
        repeat (8) @(negedge clk);
        chk(busy_n == 0 && csn_low_n == 0, "R7", "busy cycles", 64'(busy_n), 0);
        chk(rises == 0, "R7", "sclk edges", 64'(rises), 0);
        chk(64'(rx_data_o) == exp_rx, "R7", "rx unchanged", 64'(rx_data_o), exp_rx);

        // R4: divisor zero acts as one
        clear_mon();
        strobe_load(56'h3C000000000000);
        strobe_go(3'd1, 16'd0);
        wait_done();
        chk(busy_n == 17, "R4", "busy cycles div0", 64'(busy_n), 17);
        chk(lead_n == 1, "R4", "lead cycles div0", 64'(lead_n), 1);
        chk(sent == 64'h3C, "R4", "bits div0", sent, 64'h3C);

        // R9: strobes and setting changes while busy are ignored
        clear_mon();
        strobe_load(56'h96000000000000);
        strobe_go(3'd1, 16'd2);
        repeat (5) @(posedge clk);
        #1 tx_data_i = 56'h11111111111111; load_i = 1'b1; go_i = 1'b1;
        nbytes_i = 3'd7; div_i = 16'd5;
        @(posedge clk); #1 load_i = 1'b0; go_i = 1'b0;
        wait_done();
        chk(busy_n == 34, "R9", "busy cycles", 64'(busy_n), 34);
        chk(rises == 8, "R9", "rising edges", 64'(rises), 8);
        chk(sent == 64'h96, "R9", "bits sent", sent, 64'h96);
        // R8: cleared at start, right-aligned for short frame
        chk(rx_data_o == 32'h0000_0069, "R8", "rx after 1 byte", 64'(rx_data_o), 64'h69);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule